// File: doc/BRIEF.md
# Level-1 Trigger Equation Evaluator

This block takes one sample per clock from the subsystem processors. Each sample carries three calorimeter energy sums and two detector hit flags: a large-angle calorimeter, a forward calorimeter, a barrel calorimeter, a gas Cherenkov hit and a start-counter hit. Every source has its own valid strobe. The block evaluates a fixed set of physics trigger equations on every sample. It packs the results into a 32-bit trigger pattern, one bit per equation, and marks the pattern with a valid strobe.

There are two equations. The electron equation fires when the large-angle energy is above its threshold. It also fires when the forward energy is above its own threshold while the Cherenkov flag is set. The neutral-plus-charged equation fires when the barrel energy plus four times the forward energy is above a sum threshold and the start counter has a hit in the same sample.

Software sets the three thresholds through a small address/data/write-enable port. The pipeline accepts a new sample on every clock and has a fixed latency of three register stages.

Top module: `trigger_equation_unit`

## Requirements
- R1: While reset is held and right after it, `patternOut` is all zero and `patternValid` is low. The thresholds return to their defaults: large-angle 400, forward 400 and weighted sum 2000, where energies are unsigned and 1 LSB = 1 MeV.
- R2: Pattern bit 0 (electron) is 1 exactly when `laEnergy` is above the large-angle threshold, or when `fwdEnergy` is above the forward threshold and `cherHit` is 1.
- R3: Pattern bit 1 is 1 exactly when `barEnergy + 4*fwdEnergy` is above the sum threshold and `startHit` is 1. The sum is formed without overflow for all 16-bit inputs; for example, a forward energy of 16384 gives 65536.
- R4: All comparisons are strict: an energy or sum equal to its threshold does not set a bit.
- R5: A sample presented before rising edge n shows on `patternOut`/`patternValid` after rising edge n+2. A new sample is accepted on every edge, with no gaps.
- R6: Pattern bits 31 down to 2 are always zero.
- R7: If any of the five valid strobes is low for a sample, that sample's pattern is all zero and its `patternValid` is low.
- R8: A write with `cfgWe` high loads `cfgData` into a threshold. Address 0 holds the large-angle threshold (low 16 bits), address 1 the forward threshold (low 16 bits) and address 2 the 19-bit sum threshold. A write to address 3 has no effect. A write taken on an edge governs the sample captured on that same edge and every later one. Samples captured earlier keep the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| laEnergy | input | 16 | Large-angle calorimeter energy, MeV |
| laValid | input | 1 | Large-angle energy valid |
| fwdEnergy | input | 16 | Forward calorimeter energy, MeV |
| fwdValid | input | 1 | Forward energy valid |
| barEnergy | input | 16 | Barrel calorimeter energy, MeV |
| barValid | input | 1 | Barrel energy valid |
| cherHit | input | 1 | Gas Cherenkov hit flag |
| cherValid | input | 1 | Cherenkov flag valid |
| startHit | input | 1 | Start-counter hit flag |
| startValid | input | 1 | Start-counter flag valid |
| cfgAddr | input | 2 | Threshold register address |
| cfgData | input | 19 | Threshold write data |
| cfgWe | input | 1 | Threshold write enable |
| patternOut | output | 32 | Trigger pattern, bit 0 electron, bit 1 weighted-sum |
| patternValid | output | 1 | Pattern valid strobe |

## Verification
A threshold write and a sample capture can fall on the same clock edge. That edge decides which threshold judges the sample. The bench brackets a write with three back-to-back samples: one on the edge before the write, one on the write edge itself and one after. Each sample sits right at or just above the old or the new threshold. The three patterns must show the old value applied to the first sample only.

// File: rtl/trig_eq_pkg.sv
package trig_eq_pkg;

  localparam int NUM_SRC    = 5;
  localparam int CFG_ADDR_W = 2;

  localparam logic [CFG_ADDR_W-1:0] ADDR_LA_THR  = 2'd0;
  localparam logic [CFG_ADDR_W-1:0] ADDR_FWD_THR = 2'd1;
  localparam logic [CFG_ADDR_W-1:0] ADDR_SUM_THR = 2'd2;

  localparam int BIT_ELECTRON = 0;
  localparam int BIT_WSUM     = 1;

  // strobes from control to datapath, one per pipeline stage
  typedef struct packed {
    logic capture;   // stage 1: sample is complete
    logic evalOk;    // stage 2: compare results are meaningful
    logic emitOk;    // stage 3: pattern may be driven
  } stepCtl_t;

endpackage

// File: rtl/trig_eq_ctrl.sv
module trig_eq_ctrl
  import trig_eq_pkg::*;
#(
  parameter int ENERGY_W = 16,
  parameter int SUM_W    = 19,
  parameter int LA_DEF   = 400,
  parameter int FWD_DEF  = 400,
  parameter int SUM_DEF  = 2000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SRC-1:0]    validVec,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [SUM_W-1:0]      cfgData,
  input  logic                  cfgWe,
  output stepCtl_t              stepCtl,
  output logic [ENERGY_W-1:0]   laThr,
  output logic [ENERGY_W-1:0]   fwdThr,
  output logic [SUM_W-1:0]      sumThr,
  output logic                  patternValid
);

  logic sampleOk;
  logic validS1, validS2, validS3;

  assign sampleOk = &validVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validS1 <= 1'b0;
      validS2 <= 1'b0;
      validS3 <= 1'b0;
    end else begin
      validS1 <= sampleOk;
      validS2 <= validS1;
      validS3 <= validS2;
    end
  end

  always_comb begin
    stepCtl.capture = sampleOk;
    stepCtl.evalOk  = validS1;
    stepCtl.emitOk  = validS2;
  end

  assign patternValid = validS3;

  // thresholds are read in stage 2, so an update on edge n judges the
  // sample captured on edge n
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laThr  <= ENERGY_W'(LA_DEF);
      fwdThr <= ENERGY_W'(FWD_DEF);
      sumThr <= SUM_W'(SUM_DEF);
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_LA_THR:  laThr  <= cfgData[ENERGY_W-1:0];
        ADDR_FWD_THR: fwdThr <= cfgData[ENERGY_W-1:0];
        ADDR_SUM_THR: sumThr <= cfgData;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/trig_eq_datapath.sv
module trig_eq_datapath
  import trig_eq_pkg::*;
#(
  parameter int ENERGY_W  = 16,
  parameter int SUM_W     = 19,
  parameter int PATTERN_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  stepCtl_t             stepCtl,
  input  logic [ENERGY_W-1:0]  laEnergy,
  input  logic [ENERGY_W-1:0]  fwdEnergy,
  input  logic [ENERGY_W-1:0]  barEnergy,
  input  logic                 cherHit,
  input  logic                 startHit,
  input  logic [ENERGY_W-1:0]  laThr,
  input  logic [ENERGY_W-1:0]  fwdThr,
  input  logic [SUM_W-1:0]     sumThr,
  output logic [PATTERN_W-1:0] patternOut
);

  // stage 1: captured sample
  logic [ENERGY_W-1:0] laS1, fwdS1, barS1;
  logic                cherS1, startS1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laS1    <= '0;
      fwdS1   <= '0;
      barS1   <= '0;
      cherS1  <= 1'b0;
      startS1 <= 1'b0;
    end else if (stepCtl.capture) begin
      laS1    <= laEnergy;
      fwdS1   <= fwdEnergy;
      barS1   <= barEnergy;
      cherS1  <= cherHit;
      startS1 <= startHit;
    end else begin
      laS1    <= '0;
      fwdS1   <= '0;
      barS1   <= '0;
      cherS1  <= 1'b0;
      startS1 <= 1'b0;
    end
  end

  // stage 2: weighted sum and strict comparisons
  logic [SUM_W-1:0] weightedSum;
  assign weightedSum = SUM_W'(barS1) + (SUM_W'(fwdS1) << 2);

  logic laOverS2, fwdOverS2, sumOverS2, cherS2, startS2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laOverS2  <= 1'b0;
      fwdOverS2 <= 1'b0;
      sumOverS2 <= 1'b0;
      cherS2    <= 1'b0;
      startS2   <= 1'b0;
    end else begin
      laOverS2  <= stepCtl.evalOk && (laS1 > laThr);
      fwdOverS2 <= stepCtl.evalOk && (fwdS1 > fwdThr);
      sumOverS2 <= stepCtl.evalOk && (weightedSum > sumThr);
      cherS2    <= stepCtl.evalOk && cherS1;
      startS2   <= stepCtl.evalOk && startS1;
    end
  end

  // stage 3: equations into the pattern word
  logic [PATTERN_W-1:0] patternNext;

  always_comb begin
    patternNext = '0;
    patternNext[BIT_ELECTRON] = laOverS2 | (fwdOverS2 & cherS2);
    patternNext[BIT_WSUM]     = sumOverS2 & startS2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) patternOut <= '0;
    else       patternOut <= stepCtl.emitOk ? patternNext : '0;
  end

endmodule

// File: rtl/trigger_equation_unit.sv
module trigger_equation_unit
  import trig_eq_pkg::*;
#(
  parameter int ENERGY_W  = 16,
  parameter int PATTERN_W = 32,
  parameter int LA_DEF    = 400,
  parameter int FWD_DEF   = 400,
  parameter int SUM_DEF   = 2000,
  localparam int SUM_W    = ENERGY_W + 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ENERGY_W-1:0]   laEnergy,
  input  logic                  laValid,
  input  logic [ENERGY_W-1:0]   fwdEnergy,
  input  logic                  fwdValid,
  input  logic [ENERGY_W-1:0]   barEnergy,
  input  logic                  barValid,
  input  logic                  cherHit,
  input  logic                  cherValid,
  input  logic                  startHit,
  input  logic                  startValid,
  input  logic [CFG_ADDR_W-1:0] cfgAddr,
  input  logic [SUM_W-1:0]      cfgData,
  input  logic                  cfgWe,
  output logic [PATTERN_W-1:0]  patternOut,
  output logic                  patternValid
);

  stepCtl_t            stepCtl;
  logic [ENERGY_W-1:0] laThr, fwdThr;
  logic [SUM_W-1:0]    sumThr;

  trig_eq_ctrl #(
    .ENERGY_W(ENERGY_W), .SUM_W(SUM_W),
    .LA_DEF(LA_DEF), .FWD_DEF(FWD_DEF), .SUM_DEF(SUM_DEF)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .validVec({laValid, fwdValid, barValid, cherValid, startValid}),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .cfgWe(cfgWe),
    .stepCtl(stepCtl), .laThr(laThr), .fwdThr(fwdThr), .sumThr(sumThr),
    .patternValid(patternValid)
  );

  trig_eq_datapath #(
    .ENERGY_W(ENERGY_W), .SUM_W(SUM_W), .PATTERN_W(PATTERN_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .stepCtl(stepCtl),
    .laEnergy(laEnergy), .fwdEnergy(fwdEnergy), .barEnergy(barEnergy),
    .cherHit(cherHit), .startHit(startHit),
    .laThr(laThr), .fwdThr(fwdThr), .sumThr(sumThr),
    .patternOut(patternOut)
  );

endmodule

// File: rtl/trig_eq_chk.sv
module trig_eq_chk #(
  parameter int ENERGY_W  = 16,
  parameter int PATTERN_W = 32
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ENERGY_W-1:0]  laEnergy,
  input logic [ENERGY_W-1:0]  fwdEnergy,
  input logic                 cherHit,
  input logic                 startHit,
  input logic                 laValid,
  input logic                 fwdValid,
  input logic                 barValid,
  input logic                 cherValid,
  input logic                 startValid,
  input logic [PATTERN_W-1:0] patternOut,
  input logic                 patternValid
);

  logic [1:0] sinceReset;
  logic       warm;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end
  assign warm = (sinceReset == 2'd3);

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    patternOut[PATTERN_W-1:2] == '0);

  // R7
  invalid_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !patternValid |-> (patternOut == '0));

  // R5
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    warm |-> (patternValid ==
      $past(laValid && fwdValid && barValid && cherValid && startValid, 3)));

  // R2
  electron_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(laEnergy, 3) == '0 && $past(cherHit, 3) == 1'b0)
      |-> !patternOut[0]);

  // R3
  wsum_needs_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(startHit, 3) == 1'b0) |-> !patternOut[1]);

  // R4
  zero_energy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (warm && $past(laEnergy, 3) == '0 && $past(fwdEnergy, 3) == '0)
      |-> !patternOut[0]);

endmodule

bind trigger_equation_unit trig_eq_chk #(
  .ENERGY_W(ENERGY_W), .PATTERN_W(PATTERN_W)
) uChk (
  .clk(clk), .rstN(rstN), .laEnergy(laEnergy), .fwdEnergy(fwdEnergy),
  .cherHit(cherHit), .startHit(startHit),
  .laValid(laValid), .fwdValid(fwdValid), .barValid(barValid),
  .cherValid(cherValid), .startValid(startValid),
  .patternOut(patternOut), .patternValid(patternValid)
);

// File: tb/sim_trigger_equation_unit.sv
module sim_trigger_equation_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] laEnergy = '0, fwdEnergy = '0, barEnergy = '0;
  logic        laValid = 1'b0, fwdValid = 1'b0, barValid = 1'b0;
  logic        cherHit = 1'b0, cherValid = 1'b0;
  logic        startHit = 1'b0, startValid = 1'b0;
  logic [1:0]  cfgAddr = '0;
  logic [18:0] cfgData = '0;
  logic        cfgWe = 1'b0;
  logic [31:0] patternOut;
  logic        patternValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  trigger_equation_unit u0 (
    .clk(clk), .rstN(rstN),
    .laEnergy(laEnergy), .laValid(laValid),
    .fwdEnergy(fwdEnergy), .fwdValid(fwdValid),
    .barEnergy(barEnergy), .barValid(barValid),
    .cherHit(cherHit), .cherValid(cherValid),
    .startHit(startHit), .startValid(startValid),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .cfgWe(cfgWe),
    .patternOut(patternOut), .patternValid(patternValid)
  );

  // valid order {la, fwd, bar, cher, start}
  typedef struct packed {
    logic [15:0] la;
    logic [15:0] fwd;
    logic [15:0] bar;
    logic        cher;
    logic        start;
    logic [4:0]  vld;
    logic [1:0]  expBits;
    logic        expV;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{16'd401,   16'd0,     16'd0,     1'b0, 1'b0, 5'b11111, 2'b01, 1'b1, 4'd2}, // R2 large-angle
    '{16'd400,   16'd0,     16'd0,     1'b0, 1'b0, 5'b11111, 2'b00, 1'b1, 4'd4}, // R4 equal
    '{16'd0,     16'd401,   16'd0,     1'b1, 1'b0, 5'b11111, 2'b01, 1'b1, 4'd2}, // R2 fwd & cher
    '{16'd0,     16'd401,   16'd0,     1'b0, 1'b0, 5'b11111, 2'b00, 1'b1, 4'd2}, // R2 no cher
    '{16'd0,     16'd400,   16'd0,     1'b1, 1'b0, 5'b11111, 2'b00, 1'b1, 4'd4}, // R4 fwd equal
    '{16'd0,     16'd0,     16'd2001,  1'b0, 1'b1, 5'b11111, 2'b10, 1'b1, 4'd3}, // R3 barrel
    '{16'd0,     16'd0,     16'd2000,  1'b0, 1'b1, 5'b11111, 2'b00, 1'b1, 4'd4}, // R4 sum equal
    '{16'd0,     16'd500,   16'd1,     1'b0, 1'b1, 5'b11111, 2'b10, 1'b1, 4'd3}, // R3 weighted 2001
    '{16'd0,     16'd500,   16'd0,     1'b1, 1'b1, 5'b11111, 2'b01, 1'b1, 4'd3}, // R3 weighted 2000
    '{16'd65535, 16'd65535, 16'd65535, 1'b1, 1'b1, 5'b11111, 2'b11, 1'b1, 4'd3}, // R3 full scale
    '{16'd65535, 16'd65535, 16'd65535, 1'b1, 1'b1, 5'b01111, 2'b00, 1'b0, 4'd7}, // R7 la invalid
    '{16'd0,     16'd0,     16'd3000,  1'b0, 1'b0, 5'b11111, 2'b00, 1'b1, 4'd3}, // R3 no start
    '{16'd1000,  16'd0,     16'd0,     1'b0, 1'b1, 5'b11110, 2'b00, 1'b0, 4'd7}, // R7 start invalid
    '{16'd0,     16'd16384, 16'd0,     1'b0, 1'b1, 5'b11111, 2'b10, 1'b1, 4'd3}  // R3 no wrap
  };

  task automatic check(input string req, input logic [31:0] gotP,
                       input logic [31:0] expP, input logic gotV,
                       input logic expV);
    checks++;
    if (gotP !== expP || gotV !== expV) begin
      fails++;
      $display("FAIL %s: pattern=%h valid=%b expected pattern=%h valid=%b",
               req, gotP, gotV, expP, expV);
    end
  endtask

  task automatic drive(input logic [15:0] la, input logic [15:0] fwd,
                       input logic [15:0] bar, input logic cher,
                       input logic start, input logic [4:0] vld);
    laEnergy = la; fwdEnergy = fwd; barEnergy = bar;
    cherHit = cher; startHit = start;
    {laValid, fwdValid, barValid, cherValid, startValid} = vld;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet under reset
    repeat (3) @(negedge clk);
    check("R1 in reset", patternOut, 32'h0, patternValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", patternOut, 32'h0, patternValid, 1'b0);

    // table walk: vector i driven at negedge i, checked at negedge i+3 (R5)
    for (int i = 0; i < NVEC + 3; i++) begin
      if (i >= 3)
        check($sformatf("R%0d vector %0d", VECS[i-3].req, i-3), patternOut,
              {30'b0, VECS[i-3].expBits}, patternValid, VECS[i-3].expV);
      if (i < NVEC)
        drive(VECS[i].la, VECS[i].fwd, VECS[i].bar, VECS[i].cher,
              VECS[i].start, VECS[i].vld);
      else
        drive('0, '0, '0, 1'b0, 1'b0, 5'b00000);
      @(negedge clk);
    end

    // R8: write on the same edge as a sample capture
    drive(16'd401, '0, '0, 1'b0, 1'b0, 5'b11111);            // old threshold
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 2'd0; cfgData = 19'd1000;
    drive(16'd1000, '0, '0, 1'b0, 1'b0, 5'b11111);           // new, equal
    @(negedge clk);
    cfgWe = 1'b0;
    drive(16'd1001, '0, '0, 1'b0, 1'b0, 5'b11111);           // new, above
    @(negedge clk);
    drive('0, '0, '0, 1'b0, 1'b0, 5'b00000);
    check("R8 before write", patternOut, 32'h1, patternValid, 1'b1);
    @(negedge clk);
    check("R8 write edge", patternOut, 32'h0, patternValid, 1'b1);
    @(negedge clk);
    check("R8 after write", patternOut, 32'h1, patternValid, 1'b1);

    // R8: address 3 is ignored, large-angle threshold stays 1000
    cfgWe = 1'b1; cfgAddr = 2'd3; cfgData = 19'd0;
    @(negedge clk);
    cfgWe = 1'b0;
    drive(16'd500, '0, '0, 1'b0, 1'b0, 5'b11111);
    repeat (3) @(negedge clk);
    check("R8 addr3 ignored", patternOut, 32'h0, patternValid, 1'b1);

    // R8: sum threshold via address 2
    cfgWe = 1'b1; cfgAddr = 2'd2; cfgData = 19'd100;
    drive('0, '0, 16'd101, 1'b0, 1'b1, 5'b11111);
    @(negedge clk);
    cfgWe = 1'b0;
    drive('0, '0, '0, 1'b0, 1'b0, 5'b00000);
    repeat (2) @(negedge clk);
    check("R8 sum threshold", patternOut, 32'h2, patternValid, 1'b1);

    // R7: Cherenkov strobe low blanks a firing sample; R6 upper bits
    drive(16'd5000, '0, '0, 1'b1, 1'b1, 5'b11101);
    @(negedge clk);
    drive('0, '0, '0, 1'b0, 1'b0, 5'b00000);
    repeat (2) @(negedge clk);
    check("R7 cher invalid", patternOut, 32'h0, patternValid, 1'b0);
    check("R6 upper bits", {patternOut[31:2], 2'b00}, 32'h0, 1'b0, 1'b0);

    // R1: reset restores default thresholds
    rstN = 1'b0;
    @(negedge clk);
    check("R1 re-reset", patternOut, 32'h0, patternValid, 1'b0);
    rstN = 1'b1;
    drive(16'd401, '0, '0, 1'b0, 1'b0, 5'b11111);
    @(negedge clk);
    drive('0, '0, '0, 1'b0, 1'b0, 5'b00000);
    repeat (2) @(negedge clk);
    check("R1 default threshold", patternOut, 32'h1, patternValid, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule